// File: doc/BRIEF.md
# MD5 Block Compression Core

This core folds one 512-bit message block into a 128-bit MD5 chaining value. It runs one compression step per clock. A request loads the block and the incoming chaining value. The core then spends one priming cycle and 64 step cycles. It finishes by adding the final working state to the incoming chaining value and presenting the sum as the new digest. Padding the message and appending its length are left to the logic around the core.

The step loop is retimed. The sum of the A operand, the selected message word and the step constant is formed one step ahead and held in a register. Only four things then remain on the loop-carried path back to B:

- the round function,
- one adder,
- the variable rotate,
- a second adder.

The pre-sum uses a carry-save stage followed by a single adder. The two adders inside the loop stay separate, because the rotate lies between them.

Top module: `md5s_core`

## Requirements
- R1: After synchronous reset, busy and done are low and digest_o is all zero.
- R2: A start sampled while busy is low makes busy rise in the next cycle. Busy stays high for exactly 65 cycles: one priming cycle and 64 step cycles. Done is then high for exactly one cycle, which is the first cycle in which busy is low again.
- R3: Both the chaining value and the digest are packed with word A in bits 31:0, B in 63:32, C in 95:64 and D in 127:96. Message word j occupies blk_i bits 32j+31 to 32j, with the first message byte in bits 7:0.
- R4: For the padded empty message and the standard MD5 initial value, the digest is 128'h7e42f8ec_980980e9_04b2008f_d98c1dd4. In this block, word 0 is 32'h00000080 and all other words are zero. This digest reads as the hex string d41d8cd98f00b204e9800998ecf8427e.
- R5: A start raised while busy is high is ignored. The running computation's result is unchanged, and no extra busy period follows.
- R6: digest_o holds its value from the done cycle until the next accepted start completes.
- R7: For any block and any chaining value, the digest equals the standard MD5 compression of that block. The standard compression covers four rounds of 16 steps, the standard round functions, rotate amounts and message-word order, and the constants floor(|sin(i+1)|·2^32). Each output word is reduced mod 2^32 as it is added to the incoming chaining word.
- R8: A start raised in the same cycle that done is high is accepted, and a new 65-cycle busy period follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to compress; sampled only while idle |
| blk_i | input | 512 | Message block, word j at bits 32j+31:32j |
| chain_i | input | 128 | Incoming chaining value, A in the low word |
| busy | output | 1 | High while priming or stepping |
| done | output | 1 | One-cycle pulse when digest_o is updated |
| digest_o | output | 128 | Updated chaining value, A in the low word |

## Verification
The core has no free parameters: the word width, step count and round layout are fixed by the algorithm. The bench therefore builds it in its only configuration. It sweeps the full 64-step schedule on every run, using the empty-message vector and a set of random blocks with random chaining values. Expected digests come from an arithmetic model inside the bench that derives its constants from the sine function. The same runs reach the timing corners: a start raised during a run, a start raised in the done cycle, and idle holding of the digest.

// File: rtl/md5s_pkg.sv
package md5s_pkg;

    localparam int WORD_W     = 32;
    localparam int N_WORDS    = 16;
    localparam int N_STEPS    = 64;
    localparam int STEP_W     = $clog2(N_STEPS);
    localparam int SEL_W      = $clog2(N_WORDS);
    localparam int BLOCK_W    = WORD_W * N_WORDS;
    localparam int STATE_W    = WORD_W * 4;
    localparam int PRIME_LEN  = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } state_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRIME = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    function automatic word_t mix_fn(input step_t idx, input word_t b,
                                     input word_t c, input word_t d);
        case (idx[5:4])
            2'd0:    return (b & c) | (~b & d);
            2'd1:    return (b & d) | (c & ~d);
            2'd2:    return b ^ c ^ d;
            default: return c ^ (b | ~d);
        endcase
    endfunction

    function automatic logic [4:0] rot_amt(input step_t idx);
        case ({idx[5:4], idx[1:0]})
            4'h0: return 5'd7;   4'h1: return 5'd12;
            4'h2: return 5'd17;  4'h3: return 5'd22;
            4'h4: return 5'd5;   4'h5: return 5'd9;
            4'h6: return 5'd14;  4'h7: return 5'd20;
            4'h8: return 5'd4;   4'h9: return 5'd11;
            4'hA: return 5'd16;  4'hB: return 5'd23;
            4'hC: return 5'd6;   4'hD: return 5'd10;
            4'hE: return 5'd15;  default: return 5'd21;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] word_sel(input step_t idx);
        logic [SEL_W-1:0] j;
        j = idx[SEL_W-1:0];
        case (idx[5:4])
            2'd0:    return j;
            2'd1:    return SEL_W'(4'd5 * j + 4'd1);
            2'd2:    return SEL_W'(4'd3 * j + 4'd5);
            default: return SEL_W'(4'd7 * j);
        endcase
    endfunction

    function automatic word_t step_const(input step_t idx);
        case (idx)
            6'd0:  return 32'hd76aa478;  6'd1:  return 32'he8c7b756;
            6'd2:  return 32'h242070db;  6'd3:  return 32'hc1bdceee;
            6'd4:  return 32'hf57c0faf;  6'd5:  return 32'h4787c62a;
            6'd6:  return 32'ha8304613;  6'd7:  return 32'hfd469501;
            6'd8:  return 32'h698098d8;  6'd9:  return 32'h8b44f7af;
            6'd10: return 32'hffff5bb1;  6'd11: return 32'h895cd7be;
            6'd12: return 32'h6b901122;  6'd13: return 32'hfd987193;
            6'd14: return 32'ha679438e;  6'd15: return 32'h49b40821;
            6'd16: return 32'hf61e2562;  6'd17: return 32'hc040b340;
            6'd18: return 32'h265e5a51;  6'd19: return 32'he9b6c7aa;
            6'd20: return 32'hd62f105d;  6'd21: return 32'h02441453;
            6'd22: return 32'hd8a1e681;  6'd23: return 32'he7d3fbc8;
            6'd24: return 32'h21e1cde6;  6'd25: return 32'hc33707d6;
            6'd26: return 32'hf4d50d87;  6'd27: return 32'h455a14ed;
            6'd28: return 32'ha9e3e905;  6'd29: return 32'hfcefa3f8;
            6'd30: return 32'h676f02d9;  6'd31: return 32'h8d2a4c8a;
            6'd32: return 32'hfffa3942;  6'd33: return 32'h8771f681;
            6'd34: return 32'h6d9d6122;  6'd35: return 32'hfde5380c;
            6'd36: return 32'ha4beea44;  6'd37: return 32'h4bdecfa9;
            6'd38: return 32'hf6bb4b60;  6'd39: return 32'hbebfbc70;
            6'd40: return 32'h289b7ec6;  6'd41: return 32'heaa127fa;
            6'd42: return 32'hd4ef3085;  6'd43: return 32'h04881d05;
            6'd44: return 32'hd9d4d039;  6'd45: return 32'he6db99e5;
            6'd46: return 32'h1fa27cf8;  6'd47: return 32'hc4ac5665;
            6'd48: return 32'hf4292244;  6'd49: return 32'h432aff97;
            6'd50: return 32'hab9423a7;  6'd51: return 32'hfc93a039;
            6'd52: return 32'h655b59c3;  6'd53: return 32'h8f0ccc92;
            6'd54: return 32'hffeff47d;  6'd55: return 32'h85845dd1;
            6'd56: return 32'h6fa87e4f;  6'd57: return 32'hfe2ce6e0;
            6'd58: return 32'ha3014314;  6'd59: return 32'h4e0811a1;
            6'd60: return 32'hf7537e82;  6'd61: return 32'hbd3af235;
            6'd62: return 32'h2ad7d2bb;  default: return 32'heb86d391;
        endcase
    endfunction

endpackage

// File: rtl/md5s_csa3.sv
module md5s_csa3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] part_sum;
    logic [W-1:0] part_carry;

    always_comb begin
        part_sum   = x ^ y ^ z;
        part_carry = {((x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                       (y[W-2:0] & z[W-2:0])), 1'b0};
        sum_o      = part_sum + part_carry;
    end
endmodule

// File: rtl/md5s_preadd.sv
module md5s_preadd
    import md5s_pkg::*;
(
    input  word_t               a_in,
    input  logic [BLOCK_W-1:0]  blk,
    input  step_t               idx,
    output word_t               pre_o
);
    logic [SEL_W-1:0] sel;
    word_t            msg_word;
    word_t            kconst;

    always_comb begin
        sel      = word_sel(idx);
        msg_word = blk[{sel, 5'b0} +: WORD_W];
        kconst   = step_const(idx);
    end

    md5s_csa3 #(.W(WORD_W)) csa_i (
        .x     (a_in),
        .y     (msg_word),
        .z     (kconst),
        .sum_o (pre_o)
    );
endmodule

// File: rtl/md5s_step.sv
module md5s_step
    import md5s_pkg::*;
(
    input  state_t st,
    input  word_t  pre,
    input  step_t  idx,
    output state_t nxt
);
    word_t      inner;
    word_t      rotated;
    logic [4:0] sh;

    always_comb begin
        sh      = rot_amt(idx);
        inner   = pre + mix_fn(idx, st.b, st.c, st.d);
        rotated = (inner << sh) | (inner >> (6'd32 - {1'b0, sh}));
        nxt.a   = st.d;
        nxt.b   = st.b + rotated;
        nxt.c   = st.b;
        nxt.d   = st.c;
    end
endmodule

// File: rtl/md5s_core.sv
module md5s_core
    import md5s_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [BLOCK_W-1:0]  blk_i,
    input  logic [STATE_W-1:0]  chain_i,
    output logic                busy,
    output logic                done,
    output logic [STATE_W-1:0]  digest_o
);
    localparam step_t LAST_STEP = step_t'(N_STEPS - 1);

    phase_t              phase_q;
    step_t               step_q;
    state_t              st_q;
    state_t              iv_q;
    state_t              dig_q;
    word_t               pre_q;
    logic [BLOCK_W-1:0]  blk_q;
    logic                done_q;

    word_t  pre_a;
    step_t  pre_idx;
    word_t  pre_sum;
    state_t st_nxt;

    always_comb begin
        if (phase_q == PH_PRIME) begin
            pre_a   = st_q.a;
            pre_idx = '0;
        end else begin
            pre_a   = st_q.d;
            pre_idx = step_q + step_t'(1);
        end
    end

    md5s_preadd pre_i (
        .a_in  (pre_a),
        .blk   (blk_q),
        .idx   (pre_idx),
        .pre_o (pre_sum)
    );

    md5s_step step_i (
        .st  (st_q),
        .pre (pre_q),
        .idx (step_q),
        .nxt (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            st_q    <= '0;
            iv_q    <= '0;
            dig_q   <= '0;
            pre_q   <= '0;
            blk_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        blk_q   <= blk_i;
                        iv_q    <= chain_i;
                        st_q    <= chain_i;
                        phase_q <= PH_PRIME;
                    end
                end
                PH_PRIME: begin
                    pre_q   <= pre_sum;
                    step_q  <= '0;
                    phase_q <= PH_RUN;
                end
                default: begin
                    st_q   <= st_nxt;
                    pre_q  <= pre_sum;
                    step_q <= step_q + step_t'(1);
                    if (step_q == LAST_STEP) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                        dig_q.a <= iv_q.a + st_nxt.a;
                        dig_q.b <= iv_q.b + st_nxt.b;
                        dig_q.c <= iv_q.c + st_nxt.c;
                        dig_q.d <= iv_q.d + st_nxt.d;
                    end
                end
            endcase
        end
    end

    assign busy     = (phase_q != PH_IDLE);
    assign done     = done_q;
    assign digest_o = dig_q;
endmodule

// File: rtl/md5s_chk.sv
module md5s_chk
    import md5s_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [STATE_W-1:0] digest_o
);
    localparam int RUN_LEN = PRIME_LEN + N_STEPS;

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= 0;
        else              busy_cnt <= busy_cnt + 1;
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cnt == RUN_LEN));

    a_r2_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_no_overlong_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < RUN_LEN));

    a_r6_digest_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(digest_o));
endmodule

bind md5s_core md5s_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .digest_o (digest_o)
);

// File: tb/md5s_core_tb.sv
module md5s_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [511:0] blk_i;
    logic [127:0] chain_i;
    logic         busy;
    logic         done;
    logic [127:0] digest_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] kt [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    md5s_core dut_i (
        .clk(clk), .rst(rst), .start(start), .blk_i(blk_i),
        .chain_i(chain_i), .busy(busy), .done(done), .digest_o(digest_o)
    );

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic logic [127:0] ref_md5(input logic [511:0] b,
                                             input logic [127:0] iv);
        int sh [4][4] = '{'{7,12,17,22}, '{5,9,14,20},
                          '{4,11,16,23}, '{6,10,15,21}};
        logic [31:0] a, bb, c, d, f, t;
        int g;
        a = iv[31:0]; bb = iv[63:32]; c = iv[95:64]; d = iv[127:96];
        for (int i = 0; i < 64; i++) begin
            if (i < 16)      begin f = (bb & c) | (~bb & d); g = i; end
            else if (i < 32) begin f = (d & bb) | (~d & c); g = (5*i + 1) % 16; end
            else if (i < 48) begin f = bb ^ c ^ d;          g = (3*i + 5) % 16; end
            else             begin f = c ^ (bb | ~d);       g = (7*i) % 16; end
            t  = a + f + kt[i] + b[32*g +: 32];
            a  = d; d = c; c = bb;
            bb = bb + rl(t, sh[i/16][i%4]);
        end
        return {iv[127:96] + d, iv[95:64] + c, iv[63:32] + bb, iv[31:0] + a};
    endfunction

    // Drives start at the current negedge; returns cycles busy was seen high.
    task automatic run_block(input logic [511:0] b, input logic [127:0] iv,
                             input bit poke_mid, output int busy_seen);
        int guard = 0;
        busy_seen = 0;
        blk_i = b; chain_i = iv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        blk_i = ~b; chain_i = ~iv;
        while (!done && guard < 200) begin
            if (busy) busy_seen++;
            if (poke_mid && busy_seen == 10) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] std_iv;
        logic [511:0] b;
        logic [127:0] iv, exp, held;
        int bs;
        real r;

        for (int i = 0; i < 64; i++) begin
            r = $sin(real'(i + 1));
            if (r < 0.0) r = -r;
            kt[i] = 32'(longint'($floor(r * 4294967296.0)));
        end
        std_iv = {32'h10325476, 32'h98badcfe, 32'hefcdab89, 32'h67452301};

        rst = 1'b1; start = 1'b0; blk_i = '0; chain_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", {127'b0, busy}, 128'd0);
        check("R1 done", {127'b0, done}, 128'd0);
        check("R1 digest", digest_o, 128'd0);

        // R4 empty message, also R2 timing and R3 packing
        b = '0; b[7:0] = 8'h80;
        run_block(b, std_iv, 1'b0, bs);
        check("R2 busy length", 128'(bs), 128'd65);
        check("R2 done pulse", {126'b0, done, busy}, 128'b10);
        check("R4 empty digest", digest_o,
              128'h7e42f8ec_980980e9_04b2008f_d98c1dd4);
        check("R3 R7 model agrees", digest_o, ref_md5(b, std_iv));
        @(negedge clk);
        check("R2 done single cycle", {127'b0, done}, 128'd0);

        // R7 random blocks and chaining values
        for (int k = 0; k < 12; k++) begin
            for (int w = 0; w < 16; w++) b[32*w +: 32] = $urandom;
            iv = {$urandom, $urandom, $urandom, $urandom};
            if (k == 0) iv = std_iv;
            run_block(b, iv, 1'b0, bs);
            check("R7 random digest", digest_o, ref_md5(b, iv));
        end

        // R8 back-to-back: start in the done cycle
        iv = {$urandom, $urandom, $urandom, $urandom};
        for (int w = 0; w < 16; w++) b[32*w +: 32] = $urandom;
        run_block(b, iv, 1'b0, bs);
        check("R8 back-to-back busy", 128'(bs), 128'd65);
        check("R8 back-to-back digest", digest_o, ref_md5(b, iv));

        // R5 start during busy ignored
        @(negedge clk);
        for (int w = 0; w < 16; w++) b[32*w +: 32] = $urandom;
        iv = {$urandom, $urandom, $urandom, $urandom};
        exp = ref_md5(b, iv);
        run_block(b, iv, 1'b1, bs);
        check("R5 digest with mid-run start", digest_o, exp);
        check("R5 busy length unchanged", 128'(bs), 128'd65);
        @(negedge clk);
        check("R5 no extra run", {127'b0, busy}, 128'd0);

        // R6 hold while idle with changing inputs
        held = digest_o;
        for (int c = 0; c < 6; c++) begin
            blk_i = {16{$urandom}}; chain_i = {4{$urandom}};
            @(negedge clk);
        end
        check("R6 digest held", digest_o, held);
        check("R6 stays idle", {126'b0, busy, done}, 128'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule